// File: doc/BRIEF.md
# Four-Task PC Bank and Slot Scheduler

This block keeps the program counters of four hardware tasks that share one pipelined core. Every cycle it reads the next entry of a sixteen-entry time-slot table, issues the named task, and presents that task's PC to fetch. The issued task's PC then advances by one.

Control ports let a scheduler steer tasks. A jump loads one task's PC. A pause redirects a task to its own address and posts a value for a destination register. A resume moves a task's PC forward by one so that it steps past its pause. Resume can be requested in immediate form or deferred form. A deferred resume is held pending until the target task has nothing left in the four-stage pipeline and is not being issued.

A task can be single-stepped. To do this, write a table that grants the task exactly one slot, then overwrite that table in the next cycle.

Top module: `task_pc_ctrl`

## Requirements
- R1: While reset is held, all four PCs are zero, the table selects task 0 in every entry, fetch_task_o and fetch_pc_o are 0, post_we_o is 0, drained_o is 4'hF and resume_pend_o is 0.
- R2: Out of reset, one slot is issued per cycle. Entries are taken in order 0..15 and then wrap. Entry i is the 2-bit task number held in slot_tab_i bits [2i+1:2i].
- R3: A table write takes effect the following cycle and restarts the sequence at entry 0. The write cycle itself still issues from the old table.
- R4: fetch_pc_o is the current PC of the issued task, and that PC increments by one for each issue.
- R5: A jump loads jump_addr_i into the PC of task jump_task_i only. The new value is visible the next cycle.
- R6: A pause loads pause_addr_i into the PC of task pause_task_i. In the following cycle, post_we_o is high for one cycle with post_dst_o and post_val_o equal to the pause destination and value.
- R7: Each issued instruction occupies its task for four cycles after issue. drained_o[t] is high exactly when task t was not issued in any of the previous four cycles.
- R8: An immediate resume (resume_wait_i=0) adds one to the target PC at once, whatever the occupancy. This is on top of any issue increment in the same cycle.
- R9: A deferred resume (resume_wait_i=1) sets resume_pend_o[t]. In the first cycle where task t is drained and not being issued, it adds one to the PC and clears the flag.
- R10: For one task in one cycle, a jump overrides a pause, and a pause overrides a resume. A jump also clears that task's pending resume.
- R11: Writing a table with one entry for task 3 at entry 0, then rewriting it the next cycle, issues exactly one instruction of task 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_wr_i | input | 1 | Load slot table |
| slot_tab_i | input | 32 | Sixteen 2-bit task numbers |
| jump_i | input | 1 | Jump request |
| jump_task_i | input | 2 | Jump target task |
| jump_addr_i | input | 16 | Jump address |
| pause_i | input | 1 | Pause request |
| pause_task_i | input | 2 | Pausing task |
| pause_addr_i | input | 16 | Address of the pause instruction |
| pause_dst_i | input | 8 | Register to post into |
| pause_val_i | input | 32 | Value to post |
| resume_i | input | 1 | Resume request |
| resume_task_i | input | 2 | Resume target task |
| resume_wait_i | input | 1 | 1: defer until drained, 0: immediate |
| fetch_task_o | output | 2 | Task issued this cycle |
| fetch_pc_o | output | 16 | PC of issued task |
| post_we_o | output | 1 | Posted-value write strobe |
| post_dst_o | output | 8 | Posted-value destination |
| post_val_o | output | 32 | Posted value |
| drained_o | output | 4 | Per-task no instructions in flight |
| resume_pend_o | output | 4 | Per-task deferred resume waiting |

## Verification
Several rules are checked by assertions on every cycle. The occupancy counters stay within the pipeline depth. A table write restarts at entry 0. A jump lands in the named PC. A pause posts its value one cycle later. A deferred resume only clears against a drained task and adds exactly one. An untouched, unissued task keeps its PC. Other behaviours can only be shown by the bench's scenarios: the exact drain latency after a task is starved, the sums when an immediate resume coincides with an issue, the priority between simultaneous operations, and single-stepping through two back-to-back table writes.

// File: rtl/task_pc_pkg.sv
package task_pc_pkg;
  localparam int NT    = 4;
  localparam int TID_W = $clog2(NT);
  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/slot_seq.sv
module slot_seq import task_pc_pkg::*; #(
  parameter int SLOTS = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [SLOTS*TID_W-1:0] tab_i,
  output tid_t                   task_o
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [SLOTS-1:0][TID_W-1:0] tbl_q;
  logic [IDX_W-1:0]            idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
      idx_q <= '0;
    end else if (wr_i) begin
      tbl_q <= tab_i;
      idx_q <= '0;
    end else begin
      idx_q <= (idx_q == IDX_W'(SLOTS-1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign task_o = tbl_q[idx_q];
endmodule

// File: rtl/occ_track.sv
module occ_track import task_pc_pkg::*; #(
  parameter int PIPE_D = 4,
  parameter int CNT_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  tid_t                      issue_i,
  output logic [NT-1:0][CNT_W-1:0]  cnt_o,
  output logic [NT-1:0]             drained_o
);
  logic [PIPE_D-1:0]            stg_v;
  logic [PIPE_D-1:0][TID_W-1:0] stg_tk;

  // shadow of the core pipeline: which task sits in each stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v  <= '0;
      stg_tk <= '0;
    end else begin
      stg_v  <= {stg_v[PIPE_D-2:0], 1'b1};
      stg_tk <= {stg_tk[PIPE_D-2:0], issue_i};
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_cnt
    logic inc, dec;
    logic [CNT_W-1:0] cnt_q;
    assign inc = (issue_i == TID_W'(t));
    assign dec = stg_v[PIPE_D-1] && (stg_tk[PIPE_D-1] == TID_W'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec);
    end
    assign cnt_o[t]     = cnt_q;
    assign drained_o[t] = (cnt_q == '0);
  end
endmodule

// File: rtl/pc_bank.sv
module pc_bank import task_pc_pkg::*; #(
  parameter int PC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  tid_t                    issue_i,
  input  logic [NT-1:0]           drained_i,
  input  logic                    jump_i,
  input  tid_t                    jump_task_i,
  input  logic [PC_W-1:0]         jump_addr_i,
  input  logic                    pause_i,
  input  tid_t                    pause_task_i,
  input  logic [PC_W-1:0]         pause_addr_i,
  input  logic                    resume_i,
  input  tid_t                    resume_task_i,
  input  logic                    resume_wait_i,
  output logic [NT-1:0][PC_W-1:0] pc_o,
  output logic [NT-1:0]           pend_o
);
  for (genvar t = 0; t < NT; t++) begin : g_task
    logic hit_j, hit_p, hit_r, issued, pend_eff, fire;
    logic [PC_W-1:0] pc_q, pc_d;
    logic pend_q;

    assign hit_j    = jump_i   && (jump_task_i   == TID_W'(t));
    assign hit_p    = pause_i  && (pause_task_i  == TID_W'(t));
    assign hit_r    = resume_i && (resume_task_i == TID_W'(t));
    assign issued   = (issue_i == TID_W'(t));
    assign pend_eff = pend_q | (hit_r & resume_wait_i);
    // deferred step fires only once the task is out of the pipe and starved this cycle
    assign fire     = ~hit_j & ~hit_p &
                      ((hit_r & ~resume_wait_i) | (pend_eff & drained_i[t] & ~issued));

    always_comb begin
      if (hit_j)      pc_d = jump_addr_i;
      else if (hit_p) pc_d = pause_addr_i;
      else            pc_d = pc_q + PC_W'(issued) + PC_W'(fire);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q   <= '0;
        pend_q <= 1'b0;
      end else begin
        pc_q   <= pc_d;
        pend_q <= hit_j ? 1'b0 : (pend_eff & ~fire);
      end
    end

    assign pc_o[t]   = pc_q;
    assign pend_o[t] = pend_q;
  end
endmodule

// File: rtl/task_pc_ctrl.sv
module task_pc_ctrl import task_pc_pkg::*; #(
  parameter int PC_W   = 16,
  parameter int DST_W  = 8,
  parameter int DAT_W  = 32,
  parameter int SLOTS  = 16,
  parameter int PIPE_D = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   slot_wr_i,
  input  logic [SLOTS*TID_W-1:0] slot_tab_i,
  input  logic                   jump_i,
  input  logic [TID_W-1:0]       jump_task_i,
  input  logic [PC_W-1:0]        jump_addr_i,
  input  logic                   pause_i,
  input  logic [TID_W-1:0]       pause_task_i,
  input  logic [PC_W-1:0]        pause_addr_i,
  input  logic [DST_W-1:0]       pause_dst_i,
  input  logic [DAT_W-1:0]       pause_val_i,
  input  logic                   resume_i,
  input  logic [TID_W-1:0]       resume_task_i,
  input  logic                   resume_wait_i,
  output logic [TID_W-1:0]       fetch_task_o,
  output logic [PC_W-1:0]        fetch_pc_o,
  output logic                   post_we_o,
  output logic [DST_W-1:0]       post_dst_o,
  output logic [DAT_W-1:0]       post_val_o,
  output logic [NT-1:0]          drained_o,
  output logic [NT-1:0]          resume_pend_o
);
  localparam int CNT_W = $clog2(PIPE_D+1);

  tid_t                    issue_task;
  logic [NT-1:0][PC_W-1:0] pcs;
  logic [NT-1:0][CNT_W-1:0] inflight;
  logic [NT-1:0]           pend;

  slot_seq #(.SLOTS(SLOTS)) u_seq (
    .clk_i, .rst_ni, .wr_i(slot_wr_i), .tab_i(slot_tab_i), .task_o(issue_task)
  );

  occ_track #(.PIPE_D(PIPE_D), .CNT_W(CNT_W)) u_occ (
    .clk_i, .rst_ni, .issue_i(issue_task), .cnt_o(inflight), .drained_o(drained_o)
  );

  pc_bank #(.PC_W(PC_W)) u_pcs (
    .clk_i, .rst_ni, .issue_i(issue_task), .drained_i(drained_o),
    .jump_i, .jump_task_i, .jump_addr_i,
    .pause_i, .pause_task_i, .pause_addr_i,
    .resume_i, .resume_task_i, .resume_wait_i,
    .pc_o(pcs), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_we_o  <= 1'b0;
      post_dst_o <= '0;
      post_val_o <= '0;
    end else begin
      post_we_o  <= pause_i;
      post_dst_o <= pause_dst_i;
      post_val_o <= pause_val_i;
    end
  end

  assign fetch_task_o  = issue_task;
  assign fetch_pc_o    = pcs[issue_task];
  assign resume_pend_o = pend;
endmodule

// File: rtl/task_pc_ctrl_chk.sv
module task_pc_ctrl_chk import task_pc_pkg::*; #(
  parameter int PC_W   = 16,
  parameter int DST_W  = 8,
  parameter int DAT_W  = 32,
  parameter int SLOTS  = 16,
  parameter int PIPE_D = 4,
  parameter int CNT_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    slot_wr_i,
  input logic [SLOTS*TID_W-1:0]  slot_tab_i,
  input logic                    jump_i,
  input logic [TID_W-1:0]        jump_task_i,
  input logic [PC_W-1:0]         jump_addr_i,
  input logic                    pause_i,
  input logic [TID_W-1:0]        pause_task_i,
  input logic [DST_W-1:0]        pause_dst_i,
  input logic [DAT_W-1:0]        pause_val_i,
  input logic                    resume_i,
  input logic [TID_W-1:0]        resume_task_i,
  input logic                    resume_wait_i,
  input logic [TID_W-1:0]        fetch_task_o,
  input logic                    post_we_o,
  input logic [DST_W-1:0]        post_dst_o,
  input logic [DAT_W-1:0]        post_val_o,
  input logic [NT-1:0][PC_W-1:0] pcs,
  input logic [NT-1:0][CNT_W-1:0] inflight,
  input logic [NT-1:0]           pend
);
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(slot_wr_i) |-> fetch_task_o == $past(slot_tab_i[TID_W-1:0]));

  a_r6_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pause_i) |-> post_we_o && post_dst_o == $past(pause_dst_i)
                       && post_val_o == $past(pause_val_i));

  a_r6_no_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pause_i) |-> !post_we_o);

  for (genvar t = 0; t < NT; t++) begin : g_t
    a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inflight[t] <= CNT_W'(PIPE_D));

    a_r5_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(jump_i && jump_task_i == TID_W'(t)) |-> pcs[t] == $past(jump_addr_i));

    a_r9_fire_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(pend[t]) && !$past(jump_i && jump_task_i == TID_W'(t))
        && !$past(resume_i && !resume_wait_i && resume_task_i == TID_W'(t)))
      |-> $past(inflight[t]) == '0 && pcs[t] == $past(pcs[t]) + 1'b1);

    a_r4_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(fetch_task_o != TID_W'(t) && !(jump_i && jump_task_i == TID_W'(t))
            && !(pause_i && pause_task_i == TID_W'(t))
            && !(resume_i && resume_task_i == TID_W'(t)) && !pend[t])
      |-> pcs[t] == $past(pcs[t]));
  end
endmodule

bind task_pc_ctrl task_pc_ctrl_chk #(
  .PC_W(PC_W), .DST_W(DST_W), .DAT_W(DAT_W), .SLOTS(SLOTS), .PIPE_D(PIPE_D), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_wr_i(slot_wr_i), .slot_tab_i(slot_tab_i),
  .jump_i(jump_i), .jump_task_i(jump_task_i), .jump_addr_i(jump_addr_i),
  .pause_i(pause_i), .pause_task_i(pause_task_i), .pause_dst_i(pause_dst_i),
  .pause_val_i(pause_val_i), .resume_i(resume_i), .resume_task_i(resume_task_i),
  .resume_wait_i(resume_wait_i), .fetch_task_o(fetch_task_o), .post_we_o(post_we_o),
  .post_dst_o(post_dst_o), .post_val_o(post_val_o), .pcs(pcs), .inflight(inflight),
  .pend(pend)
);

// File: tb/task_pc_ctrl_bench.sv
`timescale 1ns/1ps
module task_pc_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slot_wr_i = 1'b0;
  logic [31:0] slot_tab_i = '0;
  logic        jump_i = 1'b0;
  logic [1:0]  jump_task_i = '0;
  logic [15:0] jump_addr_i = '0;
  logic        pause_i = 1'b0;
  logic [1:0]  pause_task_i = '0;
  logic [15:0] pause_addr_i = '0;
  logic [7:0]  pause_dst_i = '0;
  logic [31:0] pause_val_i = '0;
  logic        resume_i = 1'b0;
  logic [1:0]  resume_task_i = '0;
  logic        resume_wait_i = 1'b0;
  logic [1:0]  fetch_task_o;
  logic [15:0] fetch_pc_o;
  logic        post_we_o;
  logic [7:0]  post_dst_o;
  logic [31:0] post_val_o;
  logic [3:0]  drained_o;
  logic [3:0]  resume_pend_o;

  always #2 clk_i = ~clk_i;

  task_pc_ctrl u_task_pc_ctrl (.*);

  int n_chk = 0, n_fail = 0;

  // bench-side expectation state
  int          m_pc[4];
  logic [31:0] m_tbl;
  int          m_idx;
  int          m_hist[4];
  bit          m_pend[4];
  bit          m_pwe;
  logic [7:0]  m_pdst;
  logic [31:0] m_pval;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_task();
    return int'(m_tbl[m_idx*2 +: 2]);
  endfunction

  function automatic bit m_drained(int t);
    for (int k = 0; k < 4; k++) if (m_hist[k] == t) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cyc();
    int et;
    bit dr[4];
    et = m_task();
    chk("R2 fetch task", 64'(fetch_task_o), 64'(et));
    chk("R4 fetch pc", 64'(fetch_pc_o), 64'(m_pc[et]));
    for (int t = 0; t < 4; t++) begin
      chk("R7 drained", 64'(drained_o[t]), 64'(m_drained(t)));
      chk("R9 pending", 64'(resume_pend_o[t]), 64'(m_pend[t]));
    end
    chk("R6 post strobe", 64'(post_we_o), 64'(m_pwe));
    if (m_pwe) begin
      chk("R6 post dst", 64'(post_dst_o), 64'(m_pdst));
      chk("R6 post val", 64'(post_val_o), 64'(m_pval));
    end
    @(posedge clk_i);
    for (int t = 0; t < 4; t++) dr[t] = m_drained(t);
    for (int t = 0; t < 4; t++) begin
      bit hj, hp, hr, iss, pe, fire;
      hj   = jump_i && jump_task_i == 2'(t);
      hp   = pause_i && pause_task_i == 2'(t);
      hr   = resume_i && resume_task_i == 2'(t);
      iss  = (et == t);
      pe   = m_pend[t] || (hr && resume_wait_i);
      fire = !hj && !hp && ((hr && !resume_wait_i) || (pe && dr[t] && !iss));
      if (hj)      m_pc[t] = int'(jump_addr_i);
      else if (hp) m_pc[t] = int'(pause_addr_i);
      else         m_pc[t] = (m_pc[t] + int'(iss) + int'(fire)) & 16'hFFFF;
      m_pend[t] = hj ? 1'b0 : (pe && !fire);
    end
    for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = et;
    if (slot_wr_i) begin m_tbl = slot_tab_i; m_idx = 0; end
    else m_idx = (m_idx + 1) % 16;
    m_pwe = pause_i; m_pdst = pause_dst_i; m_pval = pause_val_i;
    @(negedge clk_i);
    slot_wr_i = 0; jump_i = 0; pause_i = 0; resume_i = 0; resume_wait_i = 0;
  endtask

  task automatic wr_tab(logic [31:0] v);
    slot_wr_i = 1'b1; slot_tab_i = v; cyc();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    int p, p3, pw, k_clear, steps;
    for (int t = 0; t < 4; t++) begin m_pc[t] = 0; m_pend[t] = 0; m_hist[t] = -1; end
    m_tbl = '0; m_idx = 0; m_pwe = 0; m_pdst = '0; m_pval = '0;

    // R1 reset state
    @(negedge clk_i); @(negedge clk_i);
    chk("R1 fetch task", 64'(fetch_task_o), 0);
    chk("R1 fetch pc", 64'(fetch_pc_o), 0);
    chk("R1 post strobe", 64'(post_we_o), 0);
    chk("R1 drained", 64'(drained_o), 64'hF);
    chk("R1 pending", 64'(resume_pend_o), 0);
    rst_ni = 1'b1;
    run(6);

    // R2/R3 sweep over arithmetic slot patterns
    for (int k = 1; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        for (int i = 0; i < 16; i++) pat[2*i +: 2] = 2'((i*k + j) % 4);
        wr_tab(pat);
        chk("R3 restart at entry 0", 64'(fetch_task_o), 64'(pat[1:0]));
        run(18);
      end
    end

    // R5 jump into an issuing task
    wr_tab(32'hFFFF_FFFF); run(2);
    for (int t = 0; t < 4; t++) begin
      jump_i = 1; jump_task_i = 2'(t); jump_addr_i = 16'(16'h1000*(t+1) + t); cyc();
    end
    chk("R5 jump task3", 64'(fetch_pc_o), 64'h4003);
    cyc();
    chk("R4 after jump", 64'(fetch_pc_o), 64'h4004);
    wr_tab(32'hAAAA_AAAA);
    chk("R5 jump task2", 64'(fetch_pc_o), 64'h3002);
    run(4);

    // R6 pause with posted value
    wr_tab(32'h5555_5555); run(2);
    pause_i = 1; pause_task_i = 2'd1; pause_addr_i = 16'h0040;
    pause_dst_i = 8'h15; pause_val_i = 32'hDEAD_BEEF; cyc();
    chk("R6 pause pc", 64'(fetch_pc_o), 64'h40);
    chk("R6 post strobe", 64'(post_we_o), 1);
    chk("R6 post val", 64'(post_val_o), 64'hDEAD_BEEF);
    cyc();
    chk("R6 post one cycle", 64'(post_we_o), 0);

    // R8 immediate resume on an issuing and on an idle task
    p = int'(fetch_pc_o);
    resume_i = 1; resume_task_i = 2'd1; resume_wait_i = 0; cyc();
    chk("R8 resume plus issue", 64'(fetch_pc_o), 64'(p + 2));
    p3 = m_pc[3];
    resume_i = 1; resume_task_i = 2'd3; resume_wait_i = 0; cyc();
    wr_tab(32'hFFFF_FFFF);
    chk("R8 idle resume", 64'(fetch_pc_o), 64'(p3 + 1));
    run(2);

    // R9 deferred resume waits for drain
    wr_tab(32'h5555_5555); run(5);
    pause_i = 1; pause_task_i = 2'd1; pause_addr_i = 16'h0080; cyc();
    resume_i = 1; resume_task_i = 2'd1; resume_wait_i = 1; cyc();
    chk("R9 pending set", 64'(resume_pend_o[1]), 1);
    run(2);
    pw = int'(fetch_pc_o);
    wr_tab(32'h0);
    k_clear = -1;
    for (int i = 1; i <= 8; i++) begin
      if (k_clear < 0 && resume_pend_o[1] == 1'b0) k_clear = i;
      cyc();
    end
    chk("R9 clear latency", 64'(k_clear), 6);
    wr_tab(32'h5555_5555);
    chk("R9 stepped once", 64'(fetch_pc_o), 64'(pw + 2));
    run(3);

    // R10 priorities
    wr_tab(32'hFFFF_FFFF); run(2);
    resume_i = 1; resume_task_i = 2'd3; resume_wait_i = 1; cyc();
    chk("R10 pending before jump", 64'(resume_pend_o[3]), 1);
    jump_i = 1; jump_task_i = 2'd3; jump_addr_i = 16'h0500; cyc();
    chk("R10 jump clears pending", 64'(resume_pend_o[3]), 0);
    chk("R10 jump pc", 64'(fetch_pc_o), 64'h500);
    jump_i = 1; jump_task_i = 2'd3; jump_addr_i = 16'h0600;
    resume_i = 1; resume_task_i = 2'd3; cyc();
    chk("R10 jump over resume", 64'(fetch_pc_o), 64'h600);
    pause_i = 1; pause_task_i = 2'd3; pause_addr_i = 16'h0700;
    resume_i = 1; resume_task_i = 2'd3; cyc();
    chk("R10 pause over resume", 64'(fetch_pc_o), 64'h700);
    jump_i = 1; jump_task_i = 2'd3; jump_addr_i = 16'h0800;
    pause_i = 1; pause_task_i = 2'd3; pause_addr_i = 16'h0900; cyc();
    chk("R10 jump over pause", 64'(fetch_pc_o), 64'h800);
    run(2);

    // R11 single step of task 3
    wr_tab(32'h0); run(6);
    steps = 0;
    wr_tab(32'h0000_0003);
    if (fetch_task_o == 2'd3) steps++;
    wr_tab(32'h0);
    for (int i = 0; i < 18; i++) begin
      if (fetch_task_o == 2'd3) steps++;
      cyc();
    end
    chk("R11 single step count", 64'(steps), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule